// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic datapath of a small accumulator-style controller core. Each cycle it takes a working-register operand, a file-register operand and a 4-bit operation select. It returns the result combinationally, together with the candidate flag values and a mask. The mask tells which status bits the operation is allowed to change.

A registered status byte holds five flags: carry/borrow, nibble carry, zero, signed overflow and negative. When the update enable is high, the register takes the new values for the bits in the mask and keeps the rest. The add-with-carry operation reads the stored carry bit. A multi-byte sum can then be built one byte at a time.

Subtraction takes the working register from the file operand. For subtract and decrement, the carry and nibble-carry bits report borrows.

Top module: `byte_alu_status_top`

## Requirements
- R1: The op_sel encoding is 0 pass (result = file operand), 1 add (file + working), 2 subtract, 3 add-with-carry, 4 increment file, 5 decrement file, 6 AND, 7 OR, 8 XOR. For add, result is the low 8 bits of file + working, and flag bit 0 (C) is the carry out of bit 7.
- R2: Subtract gives file − working modulo 256. C (bit 0) is 1 exactly when file < working, unsigned.
- R3: Flag bit 1 (DC) reports the nibble boundary. For add, add-with-carry and increment, it is the carry out of the low four bits. For subtract and decrement, it is 1 when the low nibble of the file operand is smaller than the low nibble being taken away.
- R4: Flag bit 2 (Z) is 1 when the 8-bit result is zero. Flag bit 4 (N) equals result bit 7. Both apply to every operation whose mask includes them.
- R5: Flag bit 3 (OV) is 1 when the two's-complement result of an arithmetic operation falls outside −128..127.
- R6: Add-with-carry gives file + working + status bit 0. C is the carry out of that sum.
- R7: Increment gives file + 1 and decrement gives file − 1. For decrement, C is set only when file = 0x00.
- R8: Arithmetic codes 1–5 give flag_mask 0x1F. Codes 0 and 6–8 give 0x14, touching only Z and N. Codes 9–15 give mask 0x00 with result = file operand. flag_next is zero outside the mask.
- R9: Status layout is C bit 0, DC bit 1, Z bit 2, OV bit 3, N bit 4. Bits 7:5 always read 0.
- R10: Reset clears the status byte. On a clock edge with upd_en high, only the masked bits take flag_next. With upd_en low, the status byte is unchanged.
- R11: Adding file 0x52 to working 0x9F gives 0xF1 with N=1, OV=0, Z=0, C=0, DC=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation select |
| w_opnd | input | 8 | Working-register operand |
| f_opnd | input | 8 | File-register operand |
| upd_en | input | 1 | Status write enable |
| result | output | 8 | Operation result |
| flag_next | output | 8 | Candidate flags, masked |
| flag_mask | output | 8 | Flags this operation may update |
| status_q | output | 8 | Registered status byte |

## Verification
The clocked properties assume op_sel, both operands and upd_en are known values that settle well before each rising edge. They also assume the add-with-carry check reads a status bit that was stable during that cycle. The stimulus respects this by changing inputs only on falling edges and sampling outputs a nanosecond later. The random mix covers all sixteen op_sel codes, including the undefined ones, and never leaves an input undriven after reset.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
   typedef enum logic [3:0] {
      OP_PASS = 4'd0,
      OP_ADD  = 4'd1,
      OP_SUB  = 4'd2,
      OP_ADDC = 4'd3,
      OP_INC  = 4'd4,
      OP_DEC  = 4'd5,
      OP_AND  = 4'd6,
      OP_OR   = 4'd7,
      OP_XOR  = 4'd8
   } alu_op_e;

   localparam int FLG_C  = 0;
   localparam int FLG_DC = 1;
   localparam int FLG_Z  = 2;
   localparam int FLG_OV = 3;
   localparam int FLG_N  = 4;
   localparam int FLAG_CNT = 5;
   localparam int STAT_W   = 8;

   localparam logic [STAT_W-1:0] MASK_ARITH = 8'h1F;
   localparam logic [STAT_W-1:0] MASK_ZN    = 8'h14;
endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
   import byte_alu_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit SPLIT_NIBBLE = 1'b1
) (
   input  logic [DATA_W-1:0] f_opnd,
   input  logic [DATA_W-1:0] w_opnd,
   input  logic [3:0]        op,
   input  logic              carry_in,
   output logic              is_arith,
   output logic [DATA_W-1:0] sum,
   output logic              c_flag,
   output logic              dc_flag,
   output logic              ov_flag
);
   localparam int MSB   = DATA_W - 1;
   localparam int NIB   = 4;
   localparam int HI_W  = DATA_W - NIB;

   logic [DATA_W-1:0] addend;
   logic              cin;
   logic              borrow_mode;
   logic              cout;
   logic              nib_cout;

   // Subtraction is formed as f + ~x + 1; carries are then inverted borrows.
   always_comb begin
      addend      = w_opnd;
      cin         = 1'b0;
      borrow_mode = 1'b0;
      is_arith    = 1'b1;
      unique case (op)
         OP_ADD:  ;
         OP_SUB:  begin addend = ~w_opnd; cin = 1'b1; borrow_mode = 1'b1; end
         OP_ADDC: cin = carry_in;
         OP_INC:  begin addend = '0; cin = 1'b1; end
         OP_DEC:  begin addend = '1; borrow_mode = 1'b1; end
         default: is_arith = 1'b0;
      endcase
   end

   generate
      if (SPLIT_NIBBLE) begin : g_split
         logic [NIB:0]  lo;
         logic [HI_W:0] hi;
         always_comb begin
            lo = {1'b0, f_opnd[NIB-1:0]} + {1'b0, addend[NIB-1:0]} + {{NIB{1'b0}}, cin};
            hi = {1'b0, f_opnd[MSB:NIB]} + {1'b0, addend[MSB:NIB]} + {{HI_W{1'b0}}, lo[NIB]};
         end
         assign sum      = {hi[HI_W-1:0], lo[NIB-1:0]};
         assign cout     = hi[HI_W];
         assign nib_cout = lo[NIB];
      end else begin : g_flat
         logic [DATA_W:0] full;
         assign full     = {1'b0, f_opnd} + {1'b0, addend} + {{DATA_W{1'b0}}, cin};
         assign sum      = full[MSB:0];
         assign cout     = full[DATA_W];
         assign nib_cout = f_opnd[NIB] ^ addend[NIB] ^ full[NIB];
      end
   endgenerate

   assign c_flag  = borrow_mode ? ~cout : cout;
   assign dc_flag = borrow_mode ? ~nib_cout : nib_cout;
   assign ov_flag = (f_opnd[MSB] == addend[MSB]) && (sum[MSB] != f_opnd[MSB]);
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
   import byte_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] f_opnd,
   input  logic [DATA_W-1:0] w_opnd,
   input  logic [3:0]        op,
   output logic              is_logic,
   output logic [DATA_W-1:0] res
);
   always_comb begin
      is_logic = 1'b1;
      res      = f_opnd;
      unique case (op)
         OP_PASS: res = f_opnd;
         OP_AND:  res = f_opnd & w_opnd;
         OP_OR:   res = f_opnd | w_opnd;
         OP_XOR:  res = f_opnd ^ w_opnd;
         default: is_logic = 1'b0;
      endcase
   end
endmodule

// File: rtl/byte_alu_status.sv
module byte_alu_status #(
   parameter int FLAGS  = 5,
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [FLAGS-1:0]  wr_mask,
   input  logic [FLAGS-1:0]  wr_flags,
   output logic [STAT_W-1:0] stat_q
);
   generate
      if (FLAGS > STAT_W) begin : g_bad_flags
         $error("byte_alu_status: FLAGS exceeds STAT_W");
      end
      for (genvar i = 0; i < STAT_W; i++) begin : g_bit
         if (i < FLAGS) begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                     stat_q[i] <= 1'b0;
               else if (wr_en && wr_mask[i])   stat_q[i] <= wr_flags[i];
            end
         end else begin : g_zero
            assign stat_q[i] = 1'b0;
         end
      end
   endgenerate

   p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[STAT_W-1:FLAGS] == '0);
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(stat_q));
   p_masked_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_mask[0]) |=> stat_q[0] == $past(stat_q[0]));
   p_write_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mask[FLAGS-1]) |=> stat_q[FLAGS-1] == $past(wr_flags[FLAGS-1]));
endmodule

// File: rtl/byte_alu_status_top.sv
module byte_alu_status_top
   import byte_alu_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit SPLIT_NIBBLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] w_opnd,
   input  logic [DATA_W-1:0] f_opnd,
   input  logic              upd_en,
   output logic [DATA_W-1:0] result,
   output logic [STAT_W-1:0] flag_next,
   output logic [STAT_W-1:0] flag_mask,
   output logic [STAT_W-1:0] status_q
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 5) begin : g_bad_width
         $error("byte_alu_status_top: DATA_W must be at least 5");
      end
   endgenerate

   logic              arith_hit, logic_hit;
   logic [DATA_W-1:0] a_sum, l_res;
   logic              a_c, a_dc, a_ov;
   logic [STAT_W-1:0] raw_flags;

   byte_alu_arith #(.DATA_W(DATA_W), .SPLIT_NIBBLE(SPLIT_NIBBLE)) u_arith (
      .f_opnd   (f_opnd),
      .w_opnd   (w_opnd),
      .op       (op_sel),
      .carry_in (status_q[FLG_C]),
      .is_arith (arith_hit),
      .sum      (a_sum),
      .c_flag   (a_c),
      .dc_flag  (a_dc),
      .ov_flag  (a_ov)
   );

   byte_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .f_opnd   (f_opnd),
      .w_opnd   (w_opnd),
      .op       (op_sel),
      .is_logic (logic_hit),
      .res      (l_res)
   );

   always_comb begin
      if (arith_hit) begin
         result    = a_sum;
         flag_mask = MASK_ARITH;
      end else if (logic_hit) begin
         result    = l_res;
         flag_mask = MASK_ZN;
      end else begin
         result    = f_opnd;
         flag_mask = '0;
      end
      raw_flags         = '0;
      raw_flags[FLG_C]  = a_c;
      raw_flags[FLG_DC] = a_dc;
      raw_flags[FLG_OV] = a_ov;
      raw_flags[FLG_Z]  = (result == '0);
      raw_flags[FLG_N]  = result[MSB];
      flag_next         = raw_flags & flag_mask;
   end

   byte_alu_status #(.FLAGS(FLAG_CNT), .STAT_W(STAT_W)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (upd_en),
      .wr_mask  (flag_mask[FLAG_CNT-1:0]),
      .wr_flags (flag_next[FLAG_CNT-1:0]),
      .stat_q   (status_q)
   );

   p_add_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 4'd1) |-> {flag_next[FLG_C], result} == ({1'b0, f_opnd} + {1'b0, w_opnd}));
   p_sub_borrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 4'd2) |-> (flag_next[FLG_C] == (f_opnd < w_opnd)) && (result == f_opnd - w_opnd));
   p_addc_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 4'd3) |-> {flag_next[FLG_C], result} ==
         ({1'b0, f_opnd} + {1'b0, w_opnd} + {{DATA_W{1'b0}}, status_q[FLG_C]}));
   p_unused_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > 4'd8) |-> (flag_mask == '0) && (result == f_opnd));
endmodule

// File: tb/byte_alu_status_top_test.sv
module byte_alu_status_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_sel = '0;
   logic [7:0] w_opnd = '0, f_opnd = '0;
   logic       upd_en = 1'b0;
   logic [7:0] result, flag_next, flag_mask, status_q;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_stat = '0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   byte_alu_status_top uut (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .w_opnd(w_opnd), .f_opnd(f_opnd),
      .upd_en(upd_en), .result(result), .flag_next(flag_next), .flag_mask(flag_mask),
      .status_q(status_q)
   );

   // returns {mask, flags, result}
   function automatic logic [23:0] model(input logic [3:0] op, input logic [7:0] w,
                                         input logic [7:0] f, input logic ci);
      int s, ss;
      logic c, dc, ov, z, n;
      logic [7:0] r, m, fl;
      int sf, sw;
      sf = int'($signed(f));
      sw = int'($signed(w));
      c = 1'b0; dc = 1'b0; ss = 0; s = int'(f); m = 8'h1F;
      case (op)
         4'd1: begin s = int'(f) + int'(w); ss = sf + sw; c = s > 255;
                     dc = (int'(f[3:0]) + int'(w[3:0])) > 15; end
         4'd2: begin s = int'(f) - int'(w); ss = sf - sw; c = f < w; dc = f[3:0] < w[3:0]; end
         4'd3: begin s = int'(f) + int'(w) + int'(ci); ss = sf + sw + int'(ci); c = s > 255;
                     dc = (int'(f[3:0]) + int'(w[3:0]) + int'(ci)) > 15; end
         4'd4: begin s = int'(f) + 1; ss = sf + 1; c = s > 255; dc = f[3:0] == 4'hF; end
         4'd5: begin s = int'(f) - 1; ss = sf - 1; c = f == 8'h00; dc = f[3:0] == 4'h0; end
         4'd0: begin s = int'(f); m = 8'h14; end
         4'd6: begin s = int'(f & w); m = 8'h14; end
         4'd7: begin s = int'(f | w); m = 8'h14; end
         4'd8: begin s = int'(f ^ w); m = 8'h14; end
         default: begin s = int'(f); m = 8'h00; end
      endcase
      r  = s[7:0];
      ov = (ss > 127) || (ss < -128);
      z  = (r == 8'h00);
      n  = r[7];
      fl = {3'b000, n, ov, z, dc, c} & m;
      return {m, fl, r};
   endfunction

   task automatic check8(input string req, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic step(input string req, input logic [3:0] op, input logic [7:0] w,
                       input logic [7:0] f, input logic en);
      logic [23:0] e;
      @(negedge clk);
      op_sel = op; w_opnd = w; f_opnd = f; upd_en = en;
      #1;
      e = model(op, w, f, exp_stat[0]);
      check8(req, "result", result, e[7:0]);
      check8(req, "flag_next", flag_next, e[15:8]);
      check8(req, "flag_mask", flag_mask, e[23:16]);
      @(posedge clk);
      if (en) exp_stat = (exp_stat & ~e[23:16]) | (e[15:8] & e[23:16]);
      #1;
      check8(req, "status_q", status_q, exp_stat);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check8("R10", "status in reset", status_q, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check8("R10", "status after reset", status_q, 8'h00);

      step("R11", 4'd1, 8'h9F, 8'h52, 1'b1);            // 0xF1, N DC
      check8("R11", "status bits", status_q, 8'h12);
      step("R2",  4'd2, 8'h07, 8'h05, 1'b1);            // borrow
      step("R2",  4'd2, 8'h05, 8'h07, 1'b1);            // f - w order
      step("R5",  4'd4, 8'h00, 8'h7F, 1'b1);            // inc overflow
      step("R7",  4'd5, 8'h00, 8'h00, 1'b1);            // dec borrow at zero
      step("R5",  4'd5, 8'h00, 8'h80, 1'b1);            // dec overflow
      step("R1",  4'd1, 8'hFF, 8'h01, 1'b1);            // carry and zero
      step("R6",  4'd3, 8'h00, 8'h00, 1'b1);            // carry in from status
      step("R3",  4'd2, 8'h01, 8'h10, 1'b1);            // nibble borrow
      step("R1",  4'd1, 8'hF0, 8'h20, 1'b1);            // set C
      step("R8",  4'd6, 8'h0F, 8'hF0, 1'b1);            // AND keeps C
      check8("R8", "carry kept", status_q & 8'h01, 8'h01);
      step("R8",  4'd12, 8'h00, 8'h00, 1'b1);           // unused code, nothing written
      step("R10", 4'd2, 8'h01, 8'h00, 1'b0);            // disabled write
      step("R4",  4'd8, 8'hA5, 8'hA5, 1'b1);            // XOR to zero
      step("R9",  4'd0, 8'h00, 8'h80, 1'b1);            // pass sets N

      for (int i = 0; i < 3000; i++) begin
         logic [3:0] op;
         logic en;
         op = 4'($urandom % 16);
         en = ($urandom % 4) != 0;
         step("R1-random", op, 8'($urandom), 8'($urandom), en);
         if (status_q[7:5] != 3'b000) check8("R9", "reserved bits", status_q & 8'hE0, 8'h00);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule